// File: doc/BRIEF.md
# Logic analyzer capture sequencer

This block runs one acquisition of a 16-channel logic analyzer. A command byte starts or halts a capture. While it runs, a programmable divider turns the core clock into a sample strobe. A per-channel trigger evaluator compares each sample with the previous one. The sequencer moves through a pre-trigger fill, a wait for the trigger, and a post-trigger fill, then returns to idle.

Downstream storage receives `sample_stb_o` for every sample to keep and `trig_pulse_o` when the trigger sample has been taken. Software polls a 16-bit status word that shows which phase the capture is in. The masks and counts are latched when a run starts. The strobe divider reads its input live.

Top module: `la_capture_seq`

## Requirements
- R1: A command of 0x03 on `cmd_i` with `cmd_valid_i` starts a capture when the block is idle. Any command value other than 0x03 and 0x00 has no effect.
- R2: A command of 0x00 returns the block to idle at the next clock edge, whatever phase it is in.
- R3: `status_o` bits [15:4] always read 0x85e. Bit 0 is idle, bit 1 is sampling active, bit 2 is trigger seen, and bit 3 is set in the wait and post-trigger phases. The resulting values are 0x85e1 after reset, 0x85e2 in pre-trigger, 0x85ea while waiting, 0x85ee in post-trigger, and 0x85e5 once a capture has completed.
- R4: The phases run pre-trigger, then wait, then post-trigger, then idle. Pre-trigger lasts `pre_cnt_i` samples. Post-trigger lasts `total_cnt_i - pre_cnt_i` samples after the trigger sample, with a minimum of 1.
- R5: A level channel (bit set in `trig_level_i`) matches when its input equals its `trig_pol_i` bit: 1 means high, 0 means low.
- R6: An edge channel matches a rising edge when its polarity bit is 0 and a falling edge when it is 1. The edge is measured against the previous sample of the same capture.
- R7: The trigger fires on a sample only when every condition in `trig_en_i & chan_en_i` holds. Channels outside `chan_en_i` take no part.
- R8: A run command with more than one enabled edge channel sets `cfg_err_o` and the block stays idle. A later accepted run clears `cfg_err_o`.
- R9: While running, `sample_stb_o` pulses once every `div_i` clocks. A divider of 0 is treated as 1.
- R10: With no enabled trigger condition, the pre-trigger count is taken as 1 and the capture goes directly to post-trigger with the trigger-seen bit set.
- R11: Trigger matches are evaluated only in the wait phase. Matches during pre-trigger are ignored.
- R12: `trig_pulse_o` is high for exactly one cycle, the first post-trigger cycle. Trigger seen stays set until the next run command.
- R13: Both counts are 40 bits wide, and no upper bit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock (maximum sample rate) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 8 | Command: 0x03 run, 0x00 halt |
| total_cnt_i | input | 40 | Total samples per capture |
| pre_cnt_i | input | 40 | Pre-trigger samples |
| div_i | input | 16 | Sample clock divider |
| chan_en_i | input | 16 | Channels in use |
| trig_en_i | input | 16 | Trigger condition enable |
| trig_level_i | input | 16 | 1 = level condition, 0 = edge condition |
| trig_pol_i | input | 16 | 1 = high/falling, 0 = low/rising |
| data_i | input | 16 | Probe inputs |
| sample_stb_o | output | 1 | Keep-sample strobe |
| trig_pulse_o | output | 1 | One-cycle trigger marker |
| status_o | output | 16 | Run status word |
| cfg_err_o | output | 1 | Rejected trigger configuration |

## Verification
A wrong phase register appears in `status_o` at the next negative clock edge. It also appears in the strobe count of a capture: too few or too many strobes before the status returns to idle. A faulty trigger compare or previous-sample register moves the strobe index at which `trig_pulse_o` appears. It can also leave the block stuck at 0x85ea, which shows up within a few dozen cycles. Truncated count registers or a wrong divider show up as a wrong strobe total or a wrong strobe spacing within one capture.

// File: rtl/la_seq_pkg.sv
package la_seq_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_PRE, PH_WAIT, PH_POST} phase_e;
  localparam logic [7:0]  CMD_RUN   = 8'h03;
  localparam logic [7:0]  CMD_HALT  = 8'h00;
  localparam logic [11:0] STATUS_HI = 12'h85e;
endpackage

// File: rtl/la_strobe_gen.sv
module la_strobe_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             stb_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_m1;

  assign div_m1 = (div_i == '0) ? '0 : div_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      stb_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      stb_o <= 1'b0;
    end else if (cnt_q >= div_m1) begin
      cnt_q <= '0;
      stb_o <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      stb_o <= 1'b0;
    end
  end

  AST_STB_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_o && en_i && div_i > 16'd1) |=> !stb_o) else $error("strobe spacing"); // R9
endmodule

// File: rtl/la_trig_eval.sv
module la_trig_eval #(
  parameter int CH_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            sample_i,
  input  logic [CH_W-1:0] data_i,
  input  logic [CH_W-1:0] use_i,
  input  logic [CH_W-1:0] en_i,
  input  logic [CH_W-1:0] level_i,
  input  logic [CH_W-1:0] pol_i,
  output logic            hit_o,
  output logic            any_o,
  output logic            edge_err_o
);
  localparam int NW = $clog2(CH_W + 1);

  logic [CH_W-1:0] act_q, lvl_q, pol_q, prev_q;
  logic            prev_vld_q;
  logic [CH_W-1:0] cond;
  logic [NW-1:0]   n_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= '0;
      lvl_q      <= '0;
      pol_q      <= '0;
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else if (load_i) begin
      act_q      <= en_i & use_i;
      lvl_q      <= level_i;
      pol_q      <= pol_i;
      prev_vld_q <= 1'b0;
    end else if (sample_i) begin
      prev_q     <= data_i;
      prev_vld_q <= 1'b1;
    end
  end

  for (genvar c = 0; c < CH_W; c++) begin : g_ch
    logic rise, fall;
    assign rise   = prev_vld_q && !prev_q[c] &&  data_i[c];
    assign fall   = prev_vld_q &&  prev_q[c] && !data_i[c];
    assign cond[c] = !act_q[c] ||
                     (lvl_q[c] ? (data_i[c] == pol_q[c]) : (pol_q[c] ? fall : rise));
  end

  always_comb begin
    n_edge = '0;
    for (int c = 0; c < CH_W; c++)
      if (en_i[c] && use_i[c] && !level_i[c]) n_edge = n_edge + 1'b1;
  end

  assign hit_o      = &cond;
  assign any_o      = |(en_i & use_i);
  assign edge_err_o = n_edge > NW'(1);
endmodule

// File: rtl/la_phase_fsm.sv
module la_phase_fsm
  import la_seq_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [7:0]       cmd_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic [CNT_W-1:0] pre_i,
  input  logic             edge_err_i,
  input  logic             trig_any_i,
  input  logic             stb_i,
  input  logic             hit_i,
  output phase_e           phase_o,
  output logic             trig_seen_o,
  output logic             trig_pulse_o,
  output logic             cfg_err_o,
  output logic             load_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q, pre_q, post_q;
  logic [CNT_W-1:0] pre_eff, post_eff;
  logic [CNT_W:0]   cnt_nx;
  logic             any_q, seen_q, pulse_q, err_q;
  logic             run_cmd, halt_cmd;

  assign run_cmd  = cmd_valid_i && cmd_i == CMD_RUN;
  assign halt_cmd = cmd_valid_i && cmd_i == CMD_HALT;
  assign load_o   = run_cmd && phase_q == PH_IDLE && !edge_err_i;
  assign pre_eff  = (!trig_any_i || pre_i == '0) ? CNT_W'(1) : pre_i;
  assign post_eff = (total_i > pre_eff) ? total_i - pre_eff : CNT_W'(1);
  assign cnt_nx   = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      pre_q   <= '0;
      post_q  <= '0;
      any_q   <= 1'b0;
      seen_q  <= 1'b0;
      pulse_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (halt_cmd) begin
        phase_q <= PH_IDLE;
      end else begin
        unique case (phase_q)
          PH_IDLE: if (run_cmd) begin
            if (edge_err_i) err_q <= 1'b1;
            else begin
              err_q   <= 1'b0;
              phase_q <= PH_PRE;
              cnt_q   <= '0;
              seen_q  <= 1'b0;
              pre_q   <= pre_eff;
              post_q  <= post_eff;
              any_q   <= trig_any_i;
            end
          end
          PH_PRE: if (stb_i) begin
            if (cnt_nx >= {1'b0, pre_q}) begin
              cnt_q <= '0;
              if (any_q) phase_q <= PH_WAIT;
              else begin
                phase_q <= PH_POST;
                seen_q  <= 1'b1;
                pulse_q <= 1'b1;
              end
            end else cnt_q <= cnt_nx[CNT_W-1:0];
          end
          PH_WAIT: if (stb_i && hit_i) begin
            phase_q <= PH_POST;
            seen_q  <= 1'b1;
            pulse_q <= 1'b1;
            cnt_q   <= '0;
          end
          PH_POST: if (stb_i) begin
            if (cnt_nx >= {1'b0, post_q}) phase_q <= PH_IDLE;
            else cnt_q <= cnt_nx[CNT_W-1:0];
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign phase_o      = phase_q;
  assign trig_seen_o  = seen_q;
  assign trig_pulse_o = pulse_q;
  assign cfg_err_o    = err_q;

  AST_HALT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_cmd |=> phase_q == PH_IDLE) else $error("halt"); // R2
  AST_ERR_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_cmd && edge_err_i && phase_q == PH_IDLE) |=> (phase_q == PH_IDLE && err_q)) else $error("err"); // R8
  AST_WAIT_AFTER_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PRE && !halt_cmd && !(stb_i && cnt_nx >= {1'b0, pre_q})) |=> phase_q == PH_PRE) else $error("pre"); // R11
  AST_PULSE_IN_POST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> (seen_q && $past(phase_q) != PH_POST)) else $error("pulse"); // R12
  AST_POST_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_POST |-> seen_q) else $error("seen"); // R12
endmodule

// File: rtl/la_capture_seq.sv
module la_capture_seq
  import la_seq_pkg::*;
#(
  parameter int CH_W  = 16,
  parameter int CNT_W = 40,
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [7:0]       cmd_i,
  input  logic [CNT_W-1:0] total_cnt_i,
  input  logic [CNT_W-1:0] pre_cnt_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [CH_W-1:0]  chan_en_i,
  input  logic [CH_W-1:0]  trig_en_i,
  input  logic [CH_W-1:0]  trig_level_i,
  input  logic [CH_W-1:0]  trig_pol_i,
  input  logic [CH_W-1:0]  data_i,
  output logic             sample_stb_o,
  output logic             trig_pulse_o,
  output logic [15:0]      status_o,
  output logic             cfg_err_o
);
  phase_e phase;
  logic   running, stb, hit, any, edge_err, seen, load;

  assign running = phase != PH_IDLE;

  la_strobe_gen #(.DIV_W(DIV_W)) u_stb (
    .clk_i, .rst_ni, .en_i(running), .div_i, .stb_o(stb)
  );

  la_trig_eval #(.CH_W(CH_W)) u_trig (
    .clk_i, .rst_ni, .load_i(load), .sample_i(stb && running), .data_i,
    .use_i(chan_en_i), .en_i(trig_en_i), .level_i(trig_level_i), .pol_i(trig_pol_i),
    .hit_o(hit), .any_o(any), .edge_err_o(edge_err)
  );

  la_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_i, .total_i(total_cnt_i), .pre_i(pre_cnt_i),
    .edge_err_i(edge_err), .trig_any_i(any), .stb_i(stb), .hit_i(hit),
    .phase_o(phase), .trig_seen_o(seen), .trig_pulse_o, .cfg_err_o, .load_o(load)
  );

  assign sample_stb_o = stb && running;
  assign status_o = {STATUS_HI, (phase == PH_WAIT || phase == PH_POST), seen, running, !running};

  AST_IDLE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] |-> (!status_o[1] && !status_o[3])) else $error("idle bits"); // R3
  AST_NO_STB_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && !cmd_valid_i) |=> !trig_pulse_o) else $error("idle pulse"); // R12
endmodule

// File: tb/la_capture_seq_tb.sv
module la_capture_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd = 8'h00;
  logic [39:0] total_cnt = '0, pre_cnt = '0;
  logic [15:0] div = 16'd1, chan_en = '0, trig_en = '0, trig_lvl = '0, trig_pol = '0, data = '0;
  logic        sample_stb, trig_pulse, cfg_err;
  logic [15:0] status;

  int errors = 0, checks = 0, cycles = 0;

  always #10 clk = ~clk;

  la_capture_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .total_cnt_i(total_cnt), .pre_cnt_i(pre_cnt), .div_i(div), .chan_en_i(chan_en),
    .trig_en_i(trig_en), .trig_level_i(trig_lvl), .trig_pol_i(trig_pol), .data_i(data),
    .sample_stb_o(sample_stb), .trig_pulse_o(trig_pulse), .status_o(status), .cfg_err_o(cfg_err)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  typedef struct packed {
    logic [15:0] pre, total, dv, use_m, en_m, lvl_m, pol_m, t_at, d_bef, d_aft, exp_stb, exp_idx;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{16'd0, 16'd5, 16'd1, 16'hffff, 16'h0000, 16'h0000, 16'h0000, 16'd0, 16'h0000, 16'h0000, 16'd5,  16'd1}, // R10
    '{16'd3, 16'd8, 16'd1, 16'hffff, 16'h0002, 16'h0002, 16'h0002, 16'd1, 16'h0000, 16'h0002, 16'd9,  16'd4}, // R5 R11
    '{16'd2, 16'd6, 16'd1, 16'hffff, 16'h0001, 16'h0000, 16'h0000, 16'd5, 16'h0000, 16'h0001, 16'd10, 16'd6}, // R6 rise
    '{16'd4, 16'd7, 16'd1, 16'hffff, 16'h0001, 16'h0000, 16'h0001, 16'd4, 16'h0001, 16'h0000, 16'd8,  16'd5}, // R6 fall
    '{16'd1, 16'd3, 16'd1, 16'hffff, 16'h0005, 16'h0004, 16'h0004, 16'd3, 16'h0004, 16'h0005, 16'd6,  16'd4}, // R7
    '{16'd9, 16'd4, 16'd1, 16'h0007, 16'h0008, 16'h0008, 16'h0008, 16'd0, 16'h0000, 16'h0000, 16'd4,  16'd1}, // R7 unused
    '{16'd0, 16'd2, 16'd0, 16'hffff, 16'h0000, 16'h0000, 16'h0000, 16'd0, 16'h0000, 16'h0000, 16'd2,  16'd1}  // R9 div0
  };

  task automatic send_cmd(input logic [7:0] c);
    cmd = c; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    int n, pulses, idx, gap, last;
    logic saw_pre, saw_wait, saw_post;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3", "reset status", status, 16'h85e1);
    chk("R3", "reset strobe", sample_stb, 0);
    chk("R8", "reset err", cfg_err, 0);

    for (int v = 0; v < 7; v++) begin
      pre_cnt = 40'(VECS[v].pre); total_cnt = 40'(VECS[v].total); div = VECS[v].dv;
      chan_en = VECS[v].use_m; trig_en = VECS[v].en_m; trig_lvl = VECS[v].lvl_m;
      trig_pol = VECS[v].pol_m; data = VECS[v].d_bef;
      send_cmd(8'h03);
      n = 0; pulses = 0; idx = 0;
      saw_pre = 0; saw_wait = 0; saw_post = 0;
      for (int c = 0; c < 2000; c++) begin
        if (status[0]) break;
        if (status == 16'h85e2) saw_pre = 1;
        if (status == 16'h85ea) saw_wait = 1;
        if (status == 16'h85ee) saw_post = 1;
        if (trig_pulse) begin pulses++; idx = n; end
        if (sample_stb) begin
          data = (n >= int'(VECS[v].t_at)) ? VECS[v].d_aft : VECS[v].d_bef;
          n++;
        end
        @(negedge clk);
      end
      chk("R4", $sformatf("vec%0d strobes", v), n, VECS[v].exp_stb);
      chk("R12", $sformatf("vec%0d pulses", v), pulses, 1);
      chk("R5 R6 R7 R11", $sformatf("vec%0d trigger index", v), idx, VECS[v].exp_idx);
      chk("R3", $sformatf("vec%0d done status", v), status, 16'h85e5);
      chk("R3", $sformatf("vec%0d saw pre", v), saw_pre, 1);
      chk("R4 R10", $sformatf("vec%0d saw wait", v), saw_wait, (VECS[v].en_m & VECS[v].use_m) != 0);
      chk("R3", $sformatf("vec%0d saw post", v), saw_post, 1);
      @(negedge clk);
    end

    // R1: unknown command ignored
    send_cmd(8'h55);
    repeat (3) begin
      chk("R1", "ignored cmd status", status, 16'h85e5);
      chk("R1", "ignored cmd strobe", sample_stb, 0);
      @(negedge clk);
    end

    // R8: two edge channels rejected
    chan_en = 16'hffff; trig_en = 16'h0003; trig_lvl = 16'h0000; trig_pol = 16'h0000;
    pre_cnt = 40'd2; total_cnt = 40'd4; div = 16'd1;
    send_cmd(8'h03);
    chk("R8", "error flag", cfg_err, 1);
    repeat (4) begin
      chk("R8", "stays idle", status, 16'h85e5);
      chk("R8", "no strobe", sample_stb, 0);
      @(negedge clk);
    end

    // R11: edge before wait ignored, then R2 halt from wait
    trig_en = 16'h0001; data = 16'h0000; pre_cnt = 40'd4; total_cnt = 40'd8;
    send_cmd(8'h03);
    chk("R8", "error cleared", cfg_err, 0);
    n = 0; pulses = 0;
    for (int c = 0; c < 40; c++) begin
      if (trig_pulse) pulses++;
      if (sample_stb) begin data = (n >= 1) ? 16'h0001 : 16'h0000; n++; end
      @(negedge clk);
    end
    chk("R11", "still waiting", status, 16'h85ea);
    chk("R11", "no pulse", pulses, 0);
    send_cmd(8'h00);
    chk("R2", "halt from wait", status, 16'h85e1);

    // R13 + R2: upper count bits kept, halt from pre
    pre_cnt = 40'h01_0000_0002; total_cnt = 40'h01_0000_0008; data = 16'h0000;
    send_cmd(8'h03);
    repeat (20) @(negedge clk);
    chk("R13", "40-bit pre count", status, 16'h85e2);
    send_cmd(8'h00);
    chk("R2", "halt from pre", status, 16'h85e1);

    // R9: divider spacing, R2 halt from post
    trig_en = 16'h0000; pre_cnt = 40'd0; total_cnt = 40'd100; div = 16'd3;
    send_cmd(8'h03);
    n = 0; gap = 0; last = 0;
    for (int c = 0; c < 40; c++) begin
      if (sample_stb) begin
        if (n > 0) gap = c - last;
        last = c; n++;
      end
      @(negedge clk);
    end
    chk("R9", "strobe spacing", gap, 3);
    chk("R9", "strobe count", n, 13);
    chk("R3", "post status", status, 16'h85ee);
    send_cmd(8'h00);
    chk("R2", "halt from post", status, 16'h85e5);
    @(negedge clk);
    chk("R2", "no strobe after halt", sample_stb, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule